// File: doc/BRIEF.md
# Ping-Pong Transmit Buffer Controller

This block is the host-facing transmit side of a small Ethernet MAC. Software sees a word-addressed window that holds two frame buffers, ping and pong. Each buffer has its own frame memory, a length register and a status word. Software fills a buffer with frame bytes, writes the byte count, then sets the busy bit in that buffer's status word. The controller streams the bytes out on a byte-wide valid/ready interface and clears busy once the last byte is accepted.

Writing busy together with the program-address bit turns the same handoff into a command. The controller then copies the first six bytes of the buffer into the station MAC address and sends nothing. When both buffers are armed, they are served in the order software armed them. Each buffer can raise a one-cycle completion pulse. A build parameter removes the pong buffer entirely.

Top module: `pp_tx_buffer`

## Requirements
- R1: After reset, `tx_valid`, `tx_done_irq`, `mac_addr` and `bus_rdata` are 0, and every status word reads 0.
- R2: Word address bit 9 selects the buffer (0 = ping at byte 0x000, 1 = pong at byte 0x800). Within a buffer, word 0x1FD (byte offset 0x7F4) is the length register and keeps the low 16 bits of a write. Word 0x1FF (byte offset 0x7FC) is the status word. Every other word is frame memory. A read returns the addressed word on `bus_rdata` one clock later.
- R3: Frame words are big-endian. The byte at offset 0 is bits 31:24 of word 0, and bytes leave in increasing offset order. Exactly as many bytes are sent as the length register holds.
- R4: Status bit 0 (busy), set by software, starts a transfer. The controller clears it after the last byte is accepted.
- R5: Writing status bits 0 and 1 together loads `mac_addr` from the buffer's first six bytes (byte 0 in bits 47:40) without sending any byte. Both bits are clear when the load completes.
- R6: When busy is cleared by completion, `tx_done_irq` pulses high for exactly one cycle if status bit 3 of that buffer is set. Otherwise it stays low.
- R7: Status bit 31 is stored and read back, and has no effect on transmission.
- R8: Writing 0 to a status word returns that buffer to idle. A transfer in progress from it stops, and `tx_valid` falls within two cycles.
- R9: When both buffers hold armed frames, they are sent in the order they were armed.
- R10: With the pong buffer disabled by parameter, writes to the pong region have no effect, reads there return 0, and nothing is transmitted for it.
- R11: While `tx_valid` is high and `tx_ready` is low, `tx_valid` and `tx_data` hold until the byte is accepted.
- R12: A frame with length 0 completes without sending any byte. Busy clears and the pulse rule of R6 applies.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Write strobe for the register/buffer window |
| bus_addr | input | AW+1 | Word address; top bit selects pong |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the address |
| tx_data | output | 8 | Frame byte |
| tx_valid | output | 1 | Frame byte is valid |
| tx_ready | input | 1 | Sink accepts the byte |
| mac_addr | output | 48 | Station MAC address |
| tx_done_irq | output | 1 | One-cycle completion pulse |

## Verification
The arming order only matters when a second buffer is armed while the first is still streaming. The bench therefore stalls the sink so ping hangs mid-frame, arms pong behind it, and then re-arms ping while pong is still sending. A scoreboard queue in arm order then catches any reordering. The abort case needs the sink held off so that a transfer is still live at the moment software writes zero to its status word.

// File: rtl/pp_tx_pkg.sv
package pp_tx_pkg;
    localparam int DATA_W         = 32;
    localparam int BYTE_W         = 8;
    localparam int LEN_W          = 16;
    localparam int MAC_W          = 48;
    localparam int LEN_OFS_BYTES  = 'h7F4;
    localparam int STAT_OFS_BYTES = 'h7FC;

    typedef struct packed {
        logic sw_flag;
        logic irq_en;
        logic prog;
        logic busy;
    } stat_t;

    typedef enum logic [1:0] {ST_IDLE, ST_SEND, ST_LOAD, ST_FIN} tx_state_e;

    function automatic stat_t unpack_stat(input logic [DATA_W-1:0] w);
        stat_t s;
        s.sw_flag = w[31];
        s.irq_en  = w[3];
        s.prog    = w[1];
        s.busy    = w[0];
        return s;
    endfunction

    function automatic logic [DATA_W-1:0] pack_stat(input stat_t s);
        logic [DATA_W-1:0] w;
        w     = '0;
        w[31] = s.sw_flag;
        w[3]  = s.irq_en;
        w[1]  = s.prog;
        w[0]  = s.busy;
        return w;
    endfunction

    function automatic logic [BYTE_W-1:0] lane_byte(input logic [DATA_W-1:0] w,
                                                    input logic [1:0] lane);
        return w[DATA_W-1-BYTE_W*int'(lane) -: BYTE_W];
    endfunction
endpackage

// File: rtl/pp_buf_bank.sv
module pp_buf_bank
    import pp_tx_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data,
    input  logic [AW-1:0]     tx_addr,
    output logic [DATA_W-1:0] tx_word,
    input  logic              clr_i,
    output stat_t             stat_o,
    output logic [LEN_W-1:0]  len_o
);
    localparam int            DEPTH    = 2**AW;
    localparam logic [AW-1:0] LEN_IDX  = AW'(LEN_OFS_BYTES / 4);
    localparam logic [AW-1:0] STAT_IDX = AW'(STAT_OFS_BYTES / 4);

    logic [DATA_W-1:0] mem [DEPTH];
    stat_t             stat_q;
    logic [LEN_W-1:0]  len_q;
    logic              stat_wr;

    assign stat_wr = wr_en && (wr_addr == STAT_IDX);

    always_ff @(posedge clk) begin
        if (wr_en) mem[wr_addr] <= wr_data;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            len_q  <= '0;
        end else begin
            if (wr_en && wr_addr == LEN_IDX) len_q <= wr_data[LEN_W-1:0];
            if (stat_wr) begin
                stat_q <= unpack_stat(wr_data);
            end else if (clr_i) begin
                stat_q.busy <= 1'b0;
                stat_q.prog <= 1'b0;
            end
        end
    end

    always_comb begin
        if (rd_addr == STAT_IDX)     rd_data = pack_stat(stat_q);
        else if (rd_addr == LEN_IDX) rd_data = {{(DATA_W-LEN_W){1'b0}}, len_q};
        else                         rd_data = mem[rd_addr];
    end

    assign tx_word = mem[tx_addr];
    assign stat_o  = stat_q;
    assign len_o   = len_q;

    // R4
    busy_clear_chk: assert property (@(posedge clk) disable iff (rst)
        (clr_i && !stat_wr) |=> (!stat_o.busy && !stat_o.prog));
endmodule

// File: rtl/pp_tx_order.sv
module pp_tx_order (
    input  logic       clk,
    input  logic       rst,
    input  logic [1:0] busy_i,
    input  logic       release_i,
    input  logic       release_sel_i,
    output logic       pick_valid_o,
    output logic       pick_sel_o
);
    logic [1:0] busy_q;
    logic [1:0] armed;
    logic       first_q;

    assign armed = busy_i & ~busy_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy_q  <= '0;
            first_q <= 1'b0;
        end else begin
            busy_q <= busy_i;
            if (release_i)                    first_q <= ~release_sel_i;
            else if (armed[0] && !busy_i[1])  first_q <= 1'b0;
            else if (armed[1] && !busy_i[0])  first_q <= 1'b1;
        end
    end

    assign pick_valid_o = |busy_i;
    assign pick_sel_o   = busy_i[first_q] ? first_q : ~first_q;

    // R9
    pick_busy_chk: assert property (@(posedge clk) disable iff (rst)
        pick_valid_o |-> busy_i[pick_sel_o]);
endmodule

// File: rtl/pp_tx_stream.sv
module pp_tx_stream
    import pp_tx_pkg::*;
#(
    parameter int AW = 9
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              pick_valid_i,
    input  logic              pick_sel_i,
    input  logic              cur_busy_i,
    input  logic              cur_prog_i,
    input  logic [LEN_W-1:0]  cur_len_i,
    input  logic [DATA_W-1:0] cur_word_i,
    input  logic              tx_ready_i,
    output logic              sel_o,
    output logic [AW-1:0]     word_idx_o,
    output logic              tx_valid_o,
    output logic [BYTE_W-1:0] tx_data_o,
    output logic              fin_o,
    output logic              release_o,
    output logic [MAC_W-1:0]  mac_o
);
    tx_state_e        state_q;
    logic             sel_q;
    logic [LEN_W-1:0] cnt_q;
    logic [MAC_W-1:0] mac_q;
    logic             abort;

    assign sel_o      = (state_q == ST_IDLE) ? pick_sel_i : sel_q;
    assign word_idx_o = cnt_q[AW+1:2];
    assign tx_valid_o = (state_q == ST_SEND);
    assign tx_data_o  = lane_byte(cur_word_i, cnt_q[1:0]);
    assign fin_o      = (state_q == ST_FIN);
    assign abort      = (state_q == ST_SEND || state_q == ST_LOAD) && !cur_busy_i;
    assign release_o  = fin_o || abort;
    assign mac_o      = mac_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            state_q <= ST_IDLE;
            sel_q   <= 1'b0;
            cnt_q   <= '0;
            mac_q   <= '0;
        end else begin
            case (state_q)
                ST_IDLE: begin
                    cnt_q <= '0;
                    if (pick_valid_i) begin
                        sel_q <= pick_sel_i;
                        if (cur_prog_i)          state_q <= ST_LOAD;
                        else if (cur_len_i == 0) state_q <= ST_FIN;
                        else                     state_q <= ST_SEND;
                    end
                end
                ST_SEND: begin
                    if (abort) begin
                        state_q <= ST_IDLE;
                    end else if (tx_ready_i) begin
                        if (cnt_q == cur_len_i - 1'b1) state_q <= ST_FIN;
                        else                           cnt_q   <= cnt_q + 1'b1;
                    end
                end
                ST_LOAD: begin
                    if (abort) begin
                        state_q <= ST_IDLE;
                    end else if (!cnt_q[2]) begin
                        mac_q[MAC_W-1:MAC_W-DATA_W] <= cur_word_i;
                        cnt_q <= LEN_W'(4);
                    end else begin
                        mac_q[MAC_W-DATA_W-1:0] <= cur_word_i[DATA_W-1:DATA_W-(MAC_W-DATA_W)];
                        state_q <= ST_FIN;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    // R11
    valid_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !tx_ready_i && cur_busy_i) |=> tx_valid_o);
    // R8
    abort_drop_chk: assert property (@(posedge clk) disable iff (rst)
        (tx_valid_o && !cur_busy_i) |=> !tx_valid_o);
endmodule

// File: rtl/pp_tx_buffer.sv
module pp_tx_buffer
    import pp_tx_pkg::*;
#(
    parameter int AW          = 9,
    parameter bit ENABLE_PONG = 1'b1
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_we,
    input  logic [AW:0] bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    output logic [7:0]  tx_data,
    output logic        tx_valid,
    input  logic        tx_ready,
    output logic [47:0] mac_addr,
    output logic        tx_done_irq
);
    localparam int NBUF = ENABLE_PONG ? 2 : 1;

    logic [DATA_W-1:0] rd_word [2];
    logic [DATA_W-1:0] tx_word [2];
    stat_t             stat    [2];
    logic [LEN_W-1:0]  len     [2];
    logic              region;
    logic              sel;
    logic [AW-1:0]     widx;
    logic              fin;
    logic              rel;
    logic              pick_valid;
    logic              pick_sel;

    assign region = bus_addr[AW];

    for (genvar b = 0; b < 2; b++) begin : g_buf
        if (b < NBUF) begin : g_on
            pp_buf_bank #(.AW(AW)) u_bank (
                .clk     (clk),
                .rst     (rst),
                .wr_en   (bus_we && region == 1'(b)),
                .wr_addr (bus_addr[AW-1:0]),
                .wr_data (bus_wdata),
                .rd_addr (bus_addr[AW-1:0]),
                .rd_data (rd_word[b]),
                .tx_addr (widx),
                .tx_word (tx_word[b]),
                .clr_i   (fin && sel == 1'(b)),
                .stat_o  (stat[b]),
                .len_o   (len[b])
            );
        end else begin : g_off
            assign rd_word[b] = '0;
            assign tx_word[b] = '0;
            assign stat[b]    = '0;
            assign len[b]     = '0;
        end
    end

    pp_tx_order u_order (
        .clk           (clk),
        .rst           (rst),
        .busy_i        ({stat[1].busy, stat[0].busy}),
        .release_i     (rel),
        .release_sel_i (sel),
        .pick_valid_o  (pick_valid),
        .pick_sel_o    (pick_sel)
    );

    pp_tx_stream #(.AW(AW)) u_stream (
        .clk          (clk),
        .rst          (rst),
        .pick_valid_i (pick_valid),
        .pick_sel_i   (pick_sel),
        .cur_busy_i   (stat[sel].busy),
        .cur_prog_i   (stat[sel].prog),
        .cur_len_i    (len[sel]),
        .cur_word_i   (tx_word[sel]),
        .tx_ready_i   (tx_ready),
        .sel_o        (sel),
        .word_idx_o   (widx),
        .tx_valid_o   (tx_valid),
        .tx_data_o    (tx_data),
        .fin_o        (fin),
        .release_o    (rel),
        .mac_o        (mac_addr)
    );

    always_ff @(posedge clk) begin
        if (rst) bus_rdata <= '0;
        else     bus_rdata <= rd_word[region];
    end

    assign tx_done_irq = fin && stat[sel].irq_en;

    // R6
    irq_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        tx_done_irq |=> !tx_done_irq);

    if (!ENABLE_PONG) begin : g_no_pong_chk
        // R10
        pong_ignored_chk: assert property (@(posedge clk) disable iff (rst)
            bus_addr[AW] |=> (bus_rdata == '0));
    end
endmodule

// File: tb/tb_pp_tx_buffer.sv
`timescale 1ns/1ps
module tb_pp_tx_buffer;
    localparam int PONG   = 512;
    localparam int LENW   = 'h1FD;
    localparam int STATW  = 'h1FF;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        we = 1'b0;
    logic [9:0]  addr = '0;
    logic [31:0] wdata = '0;
    logic [31:0] rdata, rdata_np;
    logic [7:0]  tx_data, np_tx_data;
    logic        tx_valid, np_tx_valid;
    logic        tx_ready = 1'b1;
    logic [47:0] mac, np_mac;
    logic        irq, np_irq;

    always #4 clk = ~clk;

    pp_tx_buffer dut (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata), .tx_data(tx_data), .tx_valid(tx_valid),
        .tx_ready(tx_ready), .mac_addr(mac), .tx_done_irq(irq));

    pp_tx_buffer #(.ENABLE_PONG(1'b0)) dut_np (
        .clk(clk), .rst(rst), .bus_we(we), .bus_addr(addr), .bus_wdata(wdata),
        .bus_rdata(rdata_np), .tx_data(np_tx_data), .tx_valid(np_tx_valid),
        .tx_ready(1'b1), .mac_addr(np_mac), .tx_done_irq(np_irq));

    int n_checks = 0;
    int n_fail   = 0;
    int irq_cnt  = 0;
    int byte_cnt = 0;
    int ready_mode = 0;
    bit hold_en = 1'b1;
    bit ended = 1'b0;
    logic       stall_prev = 1'b0;
    logic [7:0] stall_data = '0;
    logic [7:0] exp_q [$];

    function automatic void check(input bit ok, input string req,
                                  input logic [63:0] act, input logic [63:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endfunction

    function automatic logic [7:0] fbyte(input int seed, input int i);
        return 8'(seed + i * 13);
    endfunction

    // sink ready pattern
    initial begin
        int rc = 0;
        forever begin
            @(posedge clk);
            #1;
            rc++;
            case (ready_mode)
                0:       tx_ready = 1'b1;
                1:       tx_ready = (rc % 3) != 0;
                default: tx_ready = 1'b0;
            endcase
        end
    end

    // monitor / scoreboard
    always @(negedge clk) begin
        if (!rst) begin
            if (irq) irq_cnt++;
            if (hold_en && stall_prev)
                check(tx_valid && tx_data == stall_data, "R11",
                      {tx_valid, tx_data}, {1'b1, stall_data});
            stall_prev = tx_valid && !tx_ready;
            stall_data = tx_data;
            if (tx_valid && tx_ready) begin
                byte_cnt++;
                if (exp_q.size() == 0) begin
                    check(1'b0, "R3 unexpected byte", tx_data, 0);
                end else begin
                    logic [7:0] e;
                    e = exp_q.pop_front();
                    check(tx_data == e, "R3/R9 byte", tx_data, e);
                end
            end
        end
    end

    task automatic wr(input int a, input logic [31:0] d);
        @(negedge clk);
        we = 1'b1; addr = 10'(a); wdata = d;
        @(negedge clk);
        we = 1'b0;
    endtask

    task automatic rd(input int a, output logic [31:0] d, output logic [31:0] dn);
        @(negedge clk);
        we = 1'b0; addr = 10'(a);
        @(negedge clk);
        d = rdata; dn = rdata_np;
    endtask

    task automatic load_frame(input int base, input int len, input int seed);
        for (int w = 0; w < (len + 3) / 4; w++) begin
            logic [31:0] word;
            for (int k = 0; k < 4; k++) word[31-8*k -: 8] = fbyte(seed, 4*w + k);
            wr(base + w, word);
        end
        wr(base + LENW, 32'(len));
    endtask

    task automatic push_exp(input int len, input int seed);
        for (int i = 0; i < len; i++) exp_q.push_back(fbyte(seed, i));
    endtask

    task automatic wait_idle(input int base, input string req, input logic [31:0] exp_stat);
        logic [31:0] d, dn;
        d = 32'h1;
        for (int i = 0; i < 400 && d[0]; i++) rd(base + STATW, d, dn);
        repeat (2) @(negedge clk);
        check(d == exp_stat, req, d, exp_stat);
    endtask

    task automatic finish_run();
        if (!ended) begin
            ended = 1'b1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
            $finish;
        end
    endtask

    initial begin
        #(8 * 150000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog actual=timeout expected=done");
        finish_run();
    end

    initial begin
        logic [31:0] d, dn;
        int irq0, bc0;

        repeat (4) @(posedge clk);
        @(negedge clk);
        // R1: outputs held at reset
        check(!tx_valid && !irq && mac == 0 && rdata == 0, "R1 reset outputs",
              {tx_valid, irq, mac}, 0);
        rst = 1'b0;
        rd(STATW, d, dn);
        check(d == 0, "R1 ping status", d, 0);
        rd(PONG + STATW, d, dn);
        check(d == 0, "R1 pong status", d, 0);

        // R2: address map and readback
        wr(3, 32'hCAFEF00D);
        wr(PONG + 3, 32'h12345678);
        rd(3, d, dn);
        check(d == 32'hCAFEF00D, "R2 ping word", d, 32'hCAFEF00D);
        rd(PONG + 3, d, dn);
        check(d == 32'h12345678, "R2 pong word", d, 32'h12345678);
        wr(LENW, 32'hABCD0123);
        rd(LENW, d, dn);
        check(d == 32'h0000_0123, "R2 length low 16", d, 32'h123);

        // R3 R4: basic frame, sink always ready
        bc0 = byte_cnt;
        load_frame(0, 7, 5);
        push_exp(7, 5);
        wr(STATW, 32'h1);
        wait_idle(0, "R4 busy cleared", 32'h0);
        check(byte_cnt - bc0 == 7 && exp_q.size() == 0, "R3 byte count", byte_cnt - bc0, 7);

        // R11: back-pressure
        ready_mode = 1;
        bc0 = byte_cnt;
        load_frame(PONG, 10, 77);
        push_exp(10, 77);
        wr(PONG + STATW, 32'h1);
        wait_idle(PONG, "R4 pong busy cleared", 32'h0);
        check(byte_cnt - bc0 == 10, "R11 all bytes under stall", byte_cnt - bc0, 10);
        ready_mode = 0;

        // R6: pulse only with interrupt enable
        irq0 = irq_cnt;
        load_frame(0, 3, 21);
        push_exp(3, 21);
        wr(STATW, 32'h9);
        wait_idle(0, "R6 status keeps ie", 32'h8);
        check(irq_cnt - irq0 == 1, "R6 one pulse with ie", irq_cnt - irq0, 1);
        irq0 = irq_cnt;
        load_frame(0, 4, 33);
        push_exp(4, 33);
        wr(STATW, 32'h1);
        wait_idle(0, "R6 status no ie", 32'h0);
        check(irq_cnt == irq0, "R6 no pulse without ie", irq_cnt - irq0, 0);

        // R9: ping stuck, pong armed behind it, ping re-armed during pong
        ready_mode = 2;
        load_frame(0, 6, 90);
        push_exp(6, 90);
        wr(STATW, 32'h1);
        load_frame(PONG, 40, 40);
        push_exp(40, 40);
        wr(PONG + STATW, 32'h1);
        repeat (4) @(negedge clk);
        ready_mode = 1;
        wait_idle(0, "R9 first ping done", 32'h0);
        load_frame(0, 7, 150);
        push_exp(7, 150);
        wr(STATW, 32'h1);
        wait_idle(PONG, "R9 pong done", 32'h0);
        wait_idle(0, "R9 second ping done", 32'h0);
        check(exp_q.size() == 0, "R9 queue drained", exp_q.size(), 0);
        ready_mode = 0;

        // R5: program MAC address from pong
        bc0 = byte_cnt;
        irq0 = irq_cnt;
        wr(PONG + 0, 32'h00112233);
        wr(PONG + 1, 32'h4455AA55);
        wr(PONG + STATW, 32'h3);
        wait_idle(PONG, "R5 both bits clear", 32'h0);
        check(mac == 48'h001122334455, "R5 mac loaded", mac, 48'h001122334455);
        check(byte_cnt == bc0, "R5 no bytes sent", byte_cnt - bc0, 0);

        // R7: software flag stored and inert
        wr(STATW, 32'h8000_0000);
        rd(STATW, d, dn);
        check(d == 32'h8000_0000, "R7 flag readback", d, 32'h8000_0000);
        repeat (6) @(negedge clk);
        check(!tx_valid, "R7 flag starts nothing", tx_valid, 0);
        load_frame(0, 5, 61);
        push_exp(5, 61);
        wr(STATW, 32'h8000_0001);
        wait_idle(0, "R7 flag kept after frame", 32'h8000_0000);

        // R8: abort a live transfer
        ready_mode = 2;
        hold_en = 1'b0;
        load_frame(0, 8, 7);
        wr(STATW, 32'h1);
        repeat (4) @(negedge clk);
        check(tx_valid, "R8 transfer live", tx_valid, 1);
        wr(STATW, 32'h0);
        @(negedge clk);
        check(!tx_valid, "R8 valid dropped", tx_valid, 0);
        rd(STATW, d, dn);
        check(d == 0, "R8 status idle", d, 0);
        ready_mode = 0;
        repeat (3) @(negedge clk);
        hold_en = 1'b1;
        check(!tx_valid && exp_q.size() == 0, "R8 stays idle", tx_valid, 0);

        // R12: zero length frame
        bc0 = byte_cnt;
        irq0 = irq_cnt;
        wr(LENW, 32'h0);
        wr(STATW, 32'h9);
        wait_idle(0, "R12 busy cleared", 32'h8);
        check(byte_cnt == bc0, "R12 no bytes", byte_cnt - bc0, 0);
        check(irq_cnt - irq0 == 1, "R12 pulse", irq_cnt - irq0, 1);

        // R10: pong disabled instance
        repeat (20) @(negedge clk);
        wr(PONG + 5, 32'hDEADBEEF);
        rd(PONG + 5, d, dn);
        check(dn == 0, "R10 pong word ignored", dn, 0);
        wr(PONG + 0, 32'hFFEEDDCC);
        wr(PONG + 1, 32'hBBAA0000);
        wr(PONG + LENW, 32'h4);
        wr(PONG + STATW, 32'h3);
        rd(PONG + STATW, d, dn);
        check(dn == 0, "R10 pong status ignored", dn, 0);
        begin
            bit seen = 1'b0;
            for (int i = 0; i < 10; i++) begin
                @(negedge clk);
                if (np_tx_valid) seen = 1'b1;
            end
            check(!seen, "R10 nothing sent", seen, 0);
        end
        check(np_mac == 48'h001122334455 || np_mac == 0, "R10 mac untouched by pong",
              np_mac, 0);
        wait_idle(PONG, "R5 pong reload on full instance", 32'h0);
        check(mac == 48'hFFEEDDCCBBAA, "R5 second mac load", mac, 48'hFFEEDDCCBBAA);

        finish_run();
    end
endmodule